// File: doc/BRIEF.md
# One-time fuse array controller

This block fronts a one-time-programmable fuse store of 8 banks by 256 words, each word 8 bits wide, behind a simple register bus. Software uses a small register set to select a target, unlock programming with a key, and start either a single-bit program cycle or an explicit sense cycle. Each of these runs for a fixed, parameterised number of clocks with a busy flag raised. Completion and refusals show up as status and error bits. Both groups of bits are write-one-to-clear and can each be masked onto one interrupt line.

Two windows map every fuse word into the bus address space. Reading either window returns the word's effective value: the shadow (override) value once one has been written, otherwise the stored fuse bits. Writing the shadow window installs an override. Writing the direct window is always refused. An explicit sense cycle always returns the raw fuse bits and ignores any override. Fuse cells can only change from 0 to 1. Per-bank write, read and override protection comes from parameters.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, every control, status, error, mask and sense-data register reads 0, `irq` is low and every fuse word reads 0.
- R2: Target bank is upper-address bits 5:3. Word index is {upper-address bits 2:0, lower-address bits 7:3}. Bit index is lower-address bits 2:0. Bus address {2'b10, bank[2:0], word[7:0]} is the direct window and {2'b11, bank, word} is the shadow window. {2'b00, offset[3:0]} selects control registers: 0 function control, 1 upper address, 2 lower address, 3 key, 4 status, 5 status mask, 6 error, 7 error mask, 8 sense data.
- R3: Writing function control with bit 0 set while the key register holds 0xAA starts a program cycle. Status bit 7 reads 1 for exactly CYCLE_CLKS clocks. The addressed fuse bit is then ORed in and status bit 1 is set.
- R4: A program request when the key is not 0xAA, or when the target bank is write-protected (bank 7 by default), sets error bit 6. It starts no cycle and changes no fuse.
- R5: A fuse bit never returns to 0. Programming an already-set bit leaves the word unchanged.
- R6: Function control bit 3 with bit 0 clear starts a sense cycle of CYCLE_CLKS busy clocks. The cycle then loads the raw fuse word into sense data, ignoring any override, and sets status bit 0.
- R7: A sense request to a read-protected bank (bank 6 by default), or with function control bit 7 set, sets error bit 2 and starts no cycle.
- R8: A program request with function control bit 7 set sets error bit 7 and starts no cycle.
- R9: A function-control write while busy is ignored: the stored control value and the running cycle are unchanged.
- R10: A window read returns the override value if the word has one, else the fuse word. A read in a read-protected bank returns 0 and sets error bit 4.
- R11: A shadow-window write of a value up to 0xFF overrides the word. In an override-protected bank (bank 5 by default) it sets error bit 5 and changes nothing. A value above 0xFF is ignored with no error.
- R12: A write to the direct window changes nothing and sets error bit 3.
- R13: Status bits 1:0 and error bits 7:2 clear where a 1 is written to them. Status bit 7 reflects busy.
- R14: `irq` is high whenever any set status bit or error bit has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 13 | Word address: control block, direct window or shadow window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked status or error present |

## Verification
A corrupted fuse word, a lost override or a misrouted address field shows up on the very next window read or sense of that word. The bench therefore reads back every programmed word and its neighbour through the bus, and compares each against a model computed from the bank, word and bit arithmetic. A busy counter that is off by one changes how many consecutive status reads show bit 7. This count is checked per cycle. A refusal that wrongly starts a cycle shows up as busy on the read straight after the request, and as a changed fuse word on the readback that follows.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam int BANK_W    = 3;
  localparam int WORD_W    = 8;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = BANK_W + WORD_W;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int BUS_AW    = IDX_W + 2;
  localparam int BUS_DW    = 32;

  localparam logic [DATA_W-1:0] FUSE_KEY = 8'hAA;

  // control register offsets
  localparam logic [3:0] OFF_FCTL  = 4'd0;
  localparam logic [3:0] OFF_UADR  = 4'd1;
  localparam logic [3:0] OFF_LADR  = 4'd2;
  localparam logic [3:0] OFF_KEY   = 4'd3;
  localparam logic [3:0] OFF_STAT  = 4'd4;
  localparam logic [3:0] OFF_STATM = 4'd5;
  localparam logic [3:0] OFF_ERR   = 4'd6;
  localparam logic [3:0] OFF_ERRM  = 4'd7;
  localparam logic [3:0] OFF_SDAT  = 4'd8;

  // error bit positions
  localparam int E_PROG  = 7;
  localparam int E_WPROT = 6;
  localparam int E_OPROT = 5;
  localparam int E_RPROT = 4;
  localparam int E_WLOCK = 3;
  localparam int E_SENSE = 2;

  typedef enum logic [1:0] {
    REGION_CTRL = 2'b00,
    REGION_RSVD = 2'b01,
    REGION_DIR  = 2'b10,
    REGION_SHD  = 2'b11
  } region_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_SENSE = 1'b1
  } fuse_op_e;
endpackage

// File: rtl/fuse_cell_array.sv
module fuse_cell_array #(
  parameter int IDX_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_en,
  input  logic [IDX_W-1:0]          prog_idx,
  input  logic [$clog2(DATA_W)-1:0] prog_bit,
  input  logic [IDX_W-1:0]          rd_idx_a,
  output logic [DATA_W-1:0]         rd_data_a,
  input  logic [IDX_W-1:0]          rd_idx_b,
  output logic [DATA_W-1:0]         rd_data_b
);
  localparam int NUM_WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] cell_q [NUM_WORDS];
  logic [DATA_W-1:0] blow_mask;
  logic [DATA_W-1:0] cell_d;

  always_comb begin
    blow_mask = '0;
    blow_mask[prog_bit] = 1'b1;
    cell_d = cell_q[prog_idx] | blow_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) cell_q[i] <= '0;
    end else if (prog_en) begin
      cell_q[prog_idx] <= cell_d;
    end
  end

  assign rd_data_a = cell_q[rd_idx_a];
  assign rd_data_b = cell_q[rd_idx_b];

  // R5: a word watched on port a never loses a set bit
  assert_fuse_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_a == $past(rd_idx_a)) |-> ((rd_data_a & $past(rd_data_a)) == $past(rd_data_a)));
endmodule

// File: rtl/fuse_shadow_store.sv
module fuse_shadow_store #(
  parameter int IDX_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit
);
  localparam int NUM_WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] val_q [NUM_WORDS];
  logic              hit_q [NUM_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        val_q[i] <= '0;
        hit_q[i] <= 1'b0;
      end
    end else if (wr_en) begin
      val_q[wr_idx] <= wr_data;
      hit_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_data = val_q[rd_idx];
  assign rd_hit  = hit_q[rd_idx];

  // R11: an accepted override is visible on the next read of that word
  assert_override_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && (rd_idx == $past(wr_idx))) |-> (rd_hit && (rd_data == $past(wr_data))));
endmodule

// File: rtl/fuse_op_seq.sv
module fuse_op_seq
  import fuse_ctl_pkg::*;
#(
  parameter int CYCLE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_sense,
  output logic busy,
  output logic fin_prog,
  output logic fin_sense
);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  fuse_op_e         kind_q, kind_d;
  logic             seq_en;
  logic             last_clk;

  assign last_clk = busy_q && (cnt_q == '0);
  assign seq_en   = busy_q | start_prog | start_sense;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (busy_q) begin
      if (last_clk) busy_d = 1'b0;
      else          cnt_d  = cnt_q - 1'b1;
    end else if (start_prog || start_sense) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CYCLE_CLKS - 1);
      kind_d = start_prog ? OP_PROG : OP_SENSE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_PROG;
    end else if (seq_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign busy      = busy_q;
  assign fin_prog  = last_clk && (kind_q == OP_PROG);
  assign fin_sense = last_clk && (kind_q == OP_SENSE);

  // R3: busy cannot drop before the count runs out
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != '0)) |=> busy_q);
  // R9: the front end never launches a cycle on top of a running one
  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !(start_prog || start_sense));
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import fuse_ctl_pkg::*;
#(
  parameter int                   CYCLE_CLKS = 4,
  parameter logic [NUM_BANKS-1:0] WP_BANKS   = 8'h80,
  parameter logic [NUM_BANKS-1:0] RP_BANKS   = 8'h40,
  parameter logic [NUM_BANKS-1:0] OP_BANKS   = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq
);
  localparam int BIT_W = $clog2(DATA_W);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_q, rst_meta_q} <= 2'b00;
    else        {rst_sync_q, rst_meta_q} <= {rst_meta_q, 1'b1};
  end
  assign rst_ni = rst_sync_q;

  // registers
  logic [7:0]        fctl_q, fctl_d;
  logic [5:0]        uadr_q, uadr_d;
  logic [7:0]        ladr_q, ladr_d;
  logic [7:0]        key_q, key_d;
  logic [1:0]        stat_q, stat_d;
  logic [1:0]        statm_q, statm_d;
  logic [7:0]        err_q, err_d;
  logic [7:0]        errm_q, errm_d;
  logic [DATA_W-1:0] sdat_q, sdat_d;
  logic [IDX_W-1:0]  op_idx_q, op_idx_d;
  logic [BIT_W-1:0]  op_bit_q, op_bit_d;
  logic [BUS_DW-1:0] rdata_q, rdata_d;

  // decode
  region_e          region;
  logic [3:0]       reg_off;
  logic [IDX_W-1:0] win_idx;
  logic [BANK_W-1:0] win_bank;
  logic [BANK_W-1:0] tgt_bank;
  logic [IDX_W-1:0] tgt_idx;
  logic [BIT_W-1:0] tgt_bit;
  logic             ctrl_wr;

  assign region   = region_e'(bus_addr[BUS_AW-1 -: 2]);
  assign reg_off  = bus_addr[3:0];
  assign win_idx  = bus_addr[IDX_W-1:0];
  assign win_bank = bus_addr[IDX_W-1 -: BANK_W];
  assign tgt_bank = uadr_q[5:3];
  assign tgt_idx  = {uadr_q, ladr_q[7:3]};
  assign tgt_bit  = ladr_q[2:0];
  assign ctrl_wr  = bus_wr && (region == REGION_CTRL);

  // operation requests
  logic busy, fin_prog, fin_sense;
  logic fctl_wr, fctl_take, req_prog, req_sense, dis_req, key_ok;
  logic refuse_dis, refuse_wp, refuse_sense, start_prog, start_sense;

  assign fctl_wr      = ctrl_wr && (reg_off == OFF_FCTL);
  assign fctl_take    = fctl_wr && !busy;
  assign dis_req      = bus_wdata[7];
  assign req_prog     = fctl_take && bus_wdata[0];
  assign req_sense    = fctl_take && !bus_wdata[0] && bus_wdata[3];
  assign key_ok       = (key_q == FUSE_KEY);
  assign refuse_dis   = req_prog && dis_req;
  assign refuse_wp    = req_prog && !dis_req && (!key_ok || WP_BANKS[tgt_bank]);
  assign start_prog   = req_prog && !refuse_dis && !refuse_wp;
  assign refuse_sense = req_sense && (dis_req || RP_BANKS[tgt_bank]);
  assign start_sense  = req_sense && !refuse_sense;

  // window accesses
  logic dir_wr, shd_wr, shd_blocked, shd_we, win_rd, rd_blocked;
  assign dir_wr      = bus_wr && (region == REGION_DIR);
  assign shd_wr      = bus_wr && (region == REGION_SHD) && (bus_wdata[BUS_DW-1:DATA_W] == '0);
  assign shd_blocked = shd_wr && OP_BANKS[win_bank];
  assign shd_we      = shd_wr && !OP_BANKS[win_bank];
  assign win_rd      = bus_rd && ((region == REGION_DIR) || (region == REGION_SHD));
  assign rd_blocked  = win_rd && RP_BANKS[win_bank];

  // submodules
  logic [DATA_W-1:0] fuse_rd_a, fuse_rd_b, shd_rd;
  logic              shd_hit;

  fuse_op_seq #(.CYCLE_CLKS(CYCLE_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_ni),
    .start_prog(start_prog), .start_sense(start_sense),
    .busy(busy), .fin_prog(fin_prog), .fin_sense(fin_sense)
  );

  fuse_cell_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .rst_n(rst_ni),
    .prog_en(fin_prog), .prog_idx(op_idx_q), .prog_bit(op_bit_q),
    .rd_idx_a(win_idx), .rd_data_a(fuse_rd_a),
    .rd_idx_b(op_idx_q), .rd_data_b(fuse_rd_b)
  );

  fuse_shadow_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_ni),
    .wr_en(shd_we), .wr_idx(win_idx), .wr_data(bus_wdata[DATA_W-1:0]),
    .rd_idx(win_idx), .rd_data(shd_rd), .rd_hit(shd_hit)
  );

  // next-state
  logic [7:0] err_set, err_clr;
  logic [1:0] stat_clr;
  logic [DATA_W-1:0] win_val;

  always_comb begin
    err_set           = '0;
    err_set[E_PROG]   = refuse_dis;
    err_set[E_WPROT]  = refuse_wp;
    err_set[E_OPROT]  = shd_blocked;
    err_set[E_RPROT]  = rd_blocked;
    err_set[E_WLOCK]  = dir_wr;
    err_set[E_SENSE]  = refuse_sense;
    err_clr  = (ctrl_wr && (reg_off == OFF_ERR))  ? bus_wdata[7:0] : 8'h00;
    stat_clr = (ctrl_wr && (reg_off == OFF_STAT)) ? bus_wdata[1:0] : 2'b00;

    err_d  = (err_q & ~err_clr) | err_set;
    stat_d = (stat_q & ~stat_clr) | {fin_prog, fin_sense};

    fctl_d  = fctl_take ? (bus_wdata[7:0] & 8'hF6) : fctl_q;
    uadr_d  = (ctrl_wr && (reg_off == OFF_UADR))  ? bus_wdata[5:0] : uadr_q;
    ladr_d  = (ctrl_wr && (reg_off == OFF_LADR))  ? bus_wdata[7:0] : ladr_q;
    key_d   = (ctrl_wr && (reg_off == OFF_KEY))   ? bus_wdata[7:0] : key_q;
    statm_d = (ctrl_wr && (reg_off == OFF_STATM)) ? bus_wdata[1:0] : statm_q;
    errm_d  = (ctrl_wr && (reg_off == OFF_ERRM))  ? bus_wdata[7:0] : errm_q;
    sdat_d  = fin_sense ? fuse_rd_b : sdat_q;

    op_idx_d = (start_prog || start_sense) ? tgt_idx : op_idx_q;
    op_bit_d = (start_prog || start_sense) ? tgt_bit : op_bit_q;

    win_val = rd_blocked ? '0 : (shd_hit ? shd_rd : fuse_rd_a);

    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = '0;
      if (region == REGION_CTRL) begin
        case (reg_off)
          OFF_FCTL:  rdata_d[7:0] = fctl_q;
          OFF_UADR:  rdata_d[5:0] = uadr_q;
          OFF_LADR:  rdata_d[7:0] = ladr_q;
          OFF_KEY:   rdata_d[7:0] = key_q;
          OFF_STAT:  rdata_d[7:0] = {busy, 5'b00000, stat_q};
          OFF_STATM: rdata_d[1:0] = statm_q;
          OFF_ERR:   rdata_d[7:0] = err_q;
          OFF_ERRM:  rdata_d[7:0] = errm_q;
          OFF_SDAT:  rdata_d[DATA_W-1:0] = sdat_q;
          default:   rdata_d = '0;
        endcase
      end else if (win_rd) begin
        rdata_d[DATA_W-1:0] = win_val;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fctl_q   <= '0;
      uadr_q   <= '0;
      ladr_q   <= '0;
      key_q    <= '0;
      stat_q   <= '0;
      statm_q  <= '0;
      err_q    <= '0;
      errm_q   <= '0;
      sdat_q   <= '0;
      op_idx_q <= '0;
      op_bit_q <= '0;
      rdata_q  <= '0;
    end else begin
      fctl_q   <= fctl_d;
      uadr_q   <= uadr_d;
      ladr_q   <= ladr_d;
      key_q    <= key_d;
      stat_q   <= stat_d;
      statm_q  <= statm_d;
      err_q    <= err_d;
      errm_q   <= errm_d;
      sdat_q   <= sdat_d;
      op_idx_q <= op_idx_d;
      op_bit_q <= op_bit_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(stat_q & statm_q) || |(err_q & errm_q);

  // R3: the end of a program cycle is recorded in status
  assert_prog_done_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    fin_prog |=> stat_q[1]);
  // R4: a refused program leaves the sequencer idle and flags the error
  assert_wp_refuse_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    refuse_wp |=> (!busy && err_q[E_WPROT]));
  // R6: sense data takes the raw fuse word at the end of a sense cycle
  assert_sense_capture_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    fin_sense |=> (sdat_q == $past(fuse_rd_b)));
  // R9: control writes during a cycle leave the stored control value alone
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && fctl_wr) |=> $stable(fctl_q));
endmodule

// File: tb/otp_fuse_ctrl_bench.sv
module otp_fuse_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int chk_cnt  = 0;
  int fail_cnt = 0;

  logic [7:0] model [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_fuse_ctrl #(.CYCLE_CLKS(CYC)) u_otp_fuse_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [12:0] ctrl_a(input int off);
    return {2'b00, 7'd0, 4'(off)};
  endfunction
  function automatic logic [12:0] dir_a(input int b, input int w);
    return {2'b10, 3'(b), 8'(w)};
  endfunction
  function automatic logic [12:0] shd_a(input int b, input int w);
    return {2'b11, 3'(b), 8'(w)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic busy_count(output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      rd(ctrl_a(4), s);
      if (s[7]) n++;
      else break;
    end
  endtask

  task automatic set_tgt(input int b, input int w, input int bt);
    wr(ctrl_a(1), 32'(b * 8 + (w >> 5)));
    wr(ctrl_a(2), 32'(((w & 31) << 3) | bt));
  endtask

  task automatic prog(input int b, input int w, input int bt, input string req);
    int n;
    logic [31:0] s;
    set_tgt(b, w, bt);
    wr(ctrl_a(3), 32'hAA);
    wr(ctrl_a(0), 32'h01);
    busy_count(n);
    check({req, " busy clocks"}, 32'(n), 32'(CYC));
    rd(ctrl_a(4), s);
    check({req, " program done"}, s, 32'h2);
    wr(ctrl_a(3), 32'h00);
    wr(ctrl_a(4), 32'h3);
    model[b * 256 + w] = model[b * 256 + w] | 8'(1 << bt);
  endtask

  task automatic sense(input int b, input int w, output logic [31:0] d, output int n);
    set_tgt(b, w, 0);
    wr(ctrl_a(0), 32'h08);
    busy_count(n);
    rd(ctrl_a(8), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog expired actual=%0d expected=0", chk_cnt);
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, w, bt;
    for (int i = 0; i < 2048; i++) model[i] = 8'h00;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int off = 0; off < 9; off++) begin
      rd(ctrl_a(off), d);
      check("R1 register reset", d, 32'h0);
    end
    check("R1 irq reset", {31'd0, irq}, 32'h0);
    rd(dir_a(3, 77), d);
    check("R1 fuse reset", d, 32'h0);

    // R2 R3: program sweep over banks 0..4, two bits per word
    for (int b = 0; b < 5; b++) begin
      for (int j = 0; j < 4; j++) begin
        w  = (j * 53 + b * 7) & 255;
        bt = (j + b) % 8;
        prog(b, w, bt, "R3");
        prog(b, w, (bt + 3) % 8, "R3");
      end
    end
    for (int b = 0; b < 5; b++) begin
      for (int j = 0; j < 4; j++) begin
        w = (j * 53 + b * 7) & 255;
        rd(dir_a(b, w), d);
        check("R2 R3 readback", d, 32'(model[b * 256 + w]));
        rd(dir_a(b, (w + 1) & 255), d);
        check("R2 neighbour untouched", d, 32'(model[b * 256 + ((w + 1) & 255)]));
      end
    end

    // R5: reprogramming a set bit keeps the word
    prog(2, 14, 2, "R5");
    rd(dir_a(2, 14), d);
    check("R5 word unchanged", d, 32'(model[2 * 256 + 14]));

    // R6: sense returns raw fuse value
    for (int b = 0; b < 5; b++) begin
      w = (53 + b * 7) & 255;
      sense(b, w, d, n);
      check("R6 busy clocks", 32'(n), 32'(CYC));
      check("R6 sense data", d, 32'(model[b * 256 + w]));
      rd(ctrl_a(4), d);
      check("R6 sense done", d, 32'h1);
      wr(ctrl_a(4), 32'h1);
    end

    // R13: W1C status
    rd(ctrl_a(4), d);
    check("R13 status cleared", d, 32'h0);

    // R4: no key, then protected bank
    set_tgt(1, 200, 5);
    wr(ctrl_a(0), 32'h01);
    busy_count(n);
    check("R4 no busy without key", 32'(n), 32'h0);
    rd(ctrl_a(6), d);
    check("R4 write-protect error", d, 32'h40);
    rd(dir_a(1, 200), d);
    check("R4 fuse unchanged", d, 32'(model[456]));
    wr(ctrl_a(6), 32'h40);
    set_tgt(7, 9, 1);
    wr(ctrl_a(3), 32'hAA);
    wr(ctrl_a(0), 32'h01);
    busy_count(n);
    check("R4 no busy protected bank", 32'(n), 32'h0);
    rd(ctrl_a(6), d);
    check("R4 protected bank error", d, 32'h40);
    rd(dir_a(7, 9), d);
    check("R4 protected fuse unchanged", d, 32'h0);
    wr(ctrl_a(6), 32'h40);
    rd(ctrl_a(6), d);
    check("R13 error cleared", d, 32'h0);

    // R8: disable bit with program request
    set_tgt(1, 201, 0);
    wr(ctrl_a(0), 32'h81);
    busy_count(n);
    check("R8 no busy", 32'(n), 32'h0);
    rd(ctrl_a(6), d);
    check("R8 program error", d, 32'h80);
    rd(dir_a(1, 201), d);
    check("R8 fuse unchanged", d, 32'h0);
    wr(ctrl_a(6), 32'hFF);

    // R7: sense refusals
    sense(6, 3, d, n);
    check("R7 no busy protected sense", 32'(n), 32'h0);
    rd(ctrl_a(6), d);
    check("R7 sense error bank", d, 32'h04);
    wr(ctrl_a(6), 32'h04);
    set_tgt(0, 7, 0);
    wr(ctrl_a(0), 32'h88);
    busy_count(n);
    check("R7 no busy disabled sense", 32'(n), 32'h0);
    rd(ctrl_a(6), d);
    check("R7 sense error disable", d, 32'h04);
    wr(ctrl_a(6), 32'h04);

    // R9: control write while busy ignored
    set_tgt(3, 99, 6);
    wr(ctrl_a(0), 32'h01);
    wr(ctrl_a(0), 32'h18);
    busy_count(n);
    check("R9 busy clocks", 32'(n + 1), 32'(CYC));
    rd(ctrl_a(0), d);
    check("R9 control unchanged", d, 32'h0);
    rd(ctrl_a(4), d);
    check("R9 only program done", d, 32'h2);
    model[3 * 256 + 99] = model[3 * 256 + 99] | 8'h40;
    rd(dir_a(3, 99), d);
    check("R9 programmed", d, 32'h40);
    wr(ctrl_a(4), 32'h3);
    wr(ctrl_a(3), 32'h00);

    // R10: read-protected bank
    prog(6, 3, 0, "R10");
    rd(dir_a(6, 3), d);
    check("R10 protected read zero", d, 32'h0);
    rd(ctrl_a(6), d);
    check("R10 read-protect error", d, 32'h10);
    wr(ctrl_a(6), 32'h10);

    // R11: overrides
    w = 53 + 7;
    wr(shd_a(1, w), 32'h5A);
    rd(dir_a(1, w), d);
    check("R11 override direct", d, 32'h5A);
    rd(shd_a(1, w), d);
    check("R11 override shadow", d, 32'h5A);
    sense(1, w, d, n);
    check("R6 sense ignores override", d, 32'(model[256 + w]));
    wr(ctrl_a(4), 32'h1);
    wr(shd_a(1, w), 32'h1FF);
    rd(dir_a(1, w), d);
    check("R11 wide value ignored", d, 32'h5A);
    rd(ctrl_a(6), d);
    check("R11 wide value no error", d, 32'h0);
    wr(shd_a(5, 10), 32'h33);
    rd(dir_a(5, 10), d);
    check("R11 protected override", d, 32'h0);
    rd(ctrl_a(6), d);
    check("R11 override-protect error", d, 32'h20);
    wr(ctrl_a(6), 32'h20);

    // R12: direct window write refused
    wr(dir_a(0, 7), 32'hFF);
    rd(dir_a(0, 7), d);
    check("R12 direct write ignored", d, 32'(model[7]));
    rd(ctrl_a(6), d);
    check("R12 write-lock error", d, 32'h08);

    // R14: interrupt masking
    check("R14 irq masked off", {31'd0, irq}, 32'h0);
    wr(ctrl_a(7), 32'h08);
    check("R14 irq error", {31'd0, irq}, 32'h1);
    wr(ctrl_a(6), 32'h08);
    check("R14 irq cleared", {31'd0, irq}, 32'h0);
    wr(ctrl_a(5), 32'h2);
    prog(4, 250, 1, "R14");
    rd(dir_a(4, 250), d);
    check("R14 program landed", d, 32'(model[4 * 256 + 250]));
    set_tgt(4, 251, 2);
    wr(ctrl_a(3), 32'hAA);
    wr(ctrl_a(0), 32'h01);
    busy_count(n);
    check("R14 irq on done", {31'd0, irq}, 32'h1);
    wr(ctrl_a(4), 32'h2);
    check("R14 irq after clear", {31'd0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule